// File: doc/BRIEF.md
# Transmit Word-to-Byte Trimmer

This block sits on the host side of a transmit queue. The host writes 32-bit data words, and the block turns each word into a stream of bytes on a one-byte valid/ready output. Before a buffer is sent, the host loads a packet byte size and marks its control word as written. It then makes a setup write. The setup write carries four things: a word countdown, a leading-byte trim, a trailing-byte trim and a byte-order flag.

For each word it accepts, the block works out how many of the four bytes to keep and where the kept run starts, in transmit order. The leading trim applies only to the first word of a buffer. The trailing trim applies once the countdown has reached zero, and it stays in force for every later word until a new setup write replaces it. Independently of both trims, the block tracks how many packet bytes are still due. When fewer than four remain, that remainder sets the byte count of the word and takes the place of the trailing trim.

The host cannot write a new word while bytes of the previous word are still waiting downstream. A busy output shows when this is the case.

Top module: `tx_byte_trimmer`

## Requirements
- R1: A setup write loads a 14-bit countdown with the number of word writes in the buffer minus one. Each accepted data write decrements the countdown by one. It stops at zero and stays at zero until the next setup write.
- R2: The 2-bit leading trim removes that many bytes from the front, in transmit order, of a word accepted while the countdown is non-zero. Any accepted data write clears the leading trim, so it acts at most once per setup. When the countdown is loaded as zero, the leading trim is never applied.
- R3: The 2-bit trailing trim removes that many bytes from the end, in transmit order, of every word accepted while the countdown is zero. It is not cleared by data writes.
- R4: The remaining-byte value is loaded from the packet size at setup. It drops by the number of bytes emitted for each word. When it is below four at a data write, the word emits min(remaining, 4 minus leading trim) bytes and the trailing trim is ignored. When it is zero, the word emits no bytes.
- R5: With the byte-order flag at 1, bits [31:24] of a word are sent first and bits [7:0] last. With the flag at 0, bits [7:0] are sent first.
- R6: The bytes a word emits are a contiguous run in transmit order. The run starts after the bytes removed by the leading trim and ends before the bytes removed by the trailing trim.
- R7: Each setup write needs both a size write and a control-word mark since the last accepted setup. A setup write without them raises setupErr for exactly the following cycle, and the block ignores it, so all trim, order, countdown and remaining values stay as they were.
- R8: While outValid is 1 and outReady is 0, outValid stays 1 and outData stays unchanged in the next cycle.
- R9: busy rises in the cycle after a data write that yields at least one byte. It falls after the last byte of that word is accepted. A data write made while busy is 1 is ignored.
- R10: After reset, busy, outValid and setupErr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctlWr | input | 1 | Marks that the packet control word was written |
| sizeWr | input | 1 | Loads the packet byte size |
| sizeBytes | input | 16 | Packet size in bytes |
| setupWr | input | 1 | Setup write strobe |
| setupCount | input | 14 | Word writes in the buffer minus one |
| setupStartOff | input | 2 | Leading-byte trim |
| setupEndOff | input | 2 | Trailing-byte trim |
| setupBigEndian | input | 1 | 1 = most significant byte first |
| dataWr | input | 1 | Host data word write strobe |
| dataWord | input | 32 | Host data word |
| busy | output | 1 | Previous word still draining; data writes ignored |
| setupErr | output | 1 | One-cycle pulse after a setup write made without prior loads |
| outValid | output | 1 | Output byte valid |
| outData | output | 8 | Output byte |
| outReady | input | 1 | Downstream accepts the byte |

## Verification
Single words are sent under each byte order and with leading trims, trailing trims, a zero countdown and small packet sizes. This separates the two trims by the end of the word they cut, and it shows when the size remainder replaces the trailing trim. Multi-word buffers show that the leading trim is used once, that the trailing trim persists, and that a word with no bytes left emits nothing. A slow-ready pattern checks that byte order holds under backpressure. A setup write made without prior loads, and a data write made while busy, are each followed by a word whose bytes show that nothing changed.

// File: rtl/tx_trim_pkg.sv
package tx_trim_pkg;
  localparam int WORD_BYTES = 4;
  localparam int IDX_W = $clog2(WORD_BYTES);

  typedef struct packed {
    logic             load;
    logic [IDX_W-1:0] firstPos;
    logic [IDX_W:0]   nBytes;
    logic             bigEnd;
  } strobe_t;
endpackage

// File: rtl/tx_trim_ctrl.sv
module tx_trim_ctrl
  import tx_trim_pkg::*;
#(
  parameter int COUNT_W = 14,
  parameter int SIZE_W  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ctlWr,
  input  logic                 sizeWr,
  input  logic [SIZE_W-1:0]    sizeBytes,
  input  logic                 setupWr,
  input  logic [COUNT_W-1:0]   setupCount,
  input  logic [IDX_W-1:0]     setupStartOff,
  input  logic [IDX_W-1:0]     setupEndOff,
  input  logic                 setupBigEndian,
  input  logic                 dataWr,
  input  logic                 busy,
  output logic                 setupErr,
  output strobe_t              strobe
);
  localparam int NB_W = IDX_W + 1;
  localparam logic [NB_W-1:0] FULL = NB_W'(WORD_BYTES);

  logic [COUNT_W-1:0] cntQ;
  logic [IDX_W-1:0]   startQ, endQ;
  logic               bigQ;
  logic [SIZE_W-1:0]  remQ, sizeQ;
  logic               sizeLd, ctlLd;

  logic               accept, setupOk;
  logic [IDX_W-1:0]   headTrim, tailTrim;
  logic [NB_W-1:0]    room, nKeep;

  assign setupOk = sizeLd && ctlLd;
  assign accept  = dataWr && !busy && !setupWr;

  always_comb begin
    headTrim = (cntQ != '0) ? startQ : '0;
    tailTrim = (cntQ == '0) ? endQ : '0;
    room     = FULL - NB_W'(headTrim);
    if (remQ < SIZE_W'(WORD_BYTES)) begin
      nKeep = (remQ[NB_W-1:0] < room) ? remQ[NB_W-1:0] : room;
    end else begin
      nKeep = room - NB_W'(tailTrim);
    end
  end

  always_comb begin
    strobe.load     = accept;
    strobe.firstPos = headTrim;
    strobe.nBytes   = nKeep;
    strobe.bigEnd   = bigQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ     <= '0;
      startQ   <= '0;
      endQ     <= '0;
      bigQ     <= 1'b0;
      remQ     <= '0;
      sizeQ    <= '0;
      sizeLd   <= 1'b0;
      ctlLd    <= 1'b0;
      setupErr <= 1'b0;
    end else begin
      setupErr <= setupWr && !setupOk;
      if (setupWr) begin
        if (setupOk) begin
          cntQ   <= setupCount;
          startQ <= setupStartOff;
          endQ   <= setupEndOff;
          bigQ   <= setupBigEndian;
          remQ   <= sizeQ;
          sizeLd <= 1'b0;
          ctlLd  <= 1'b0;
        end
      end else if (accept) begin
        if (cntQ != '0) cntQ <= cntQ - 1'b1;
        startQ <= '0;
        remQ   <= remQ - SIZE_W'(nKeep);
      end
      if (sizeWr) begin
        sizeQ  <= sizeBytes;
        sizeLd <= 1'b1;
      end
      if (ctlWr) ctlLd <= 1'b1;
    end
  end
endmodule

// File: rtl/tx_trim_datapath.sv
module tx_trim_datapath
  import tx_trim_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     strobe,
  input  logic [8*WORD_BYTES-1:0] dataWord,
  input  logic        outReady,
  output logic        outValid,
  output logic [7:0]  outData,
  output logic        busy
);
  logic [8*WORD_BYTES-1:0] wordQ;
  logic [IDX_W-1:0]        posQ, lastQ;
  logic                    bigQ, activeQ;
  logic [7:0]              byteLane [WORD_BYTES];
  logic [IDX_W-1:0]        laneSel;

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign byteLane[g] = wordQ[8*g +: 8];
  end

  assign laneSel  = bigQ ? IDX_W'(WORD_BYTES - 1) - posQ : posQ;
  assign outData  = byteLane[laneSel];
  assign outValid = activeQ;
  assign busy     = activeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ   <= '0;
      posQ    <= '0;
      lastQ   <= '0;
      bigQ    <= 1'b0;
      activeQ <= 1'b0;
    end else if (strobe.load) begin
      if (strobe.nBytes != '0) begin
        wordQ   <= dataWord;
        bigQ    <= strobe.bigEnd;
        posQ    <= strobe.firstPos;
        lastQ   <= IDX_W'({1'b0, strobe.firstPos} + strobe.nBytes - 1'b1);
        activeQ <= 1'b1;
      end
    end else if (activeQ && outReady) begin
      if (posQ == lastQ) activeQ <= 1'b0;
      else               posQ    <= posQ + 1'b1;
    end
  end
endmodule

// File: rtl/tx_byte_trimmer.sv
module tx_byte_trimmer
  import tx_trim_pkg::*;
#(
  parameter int COUNT_W = 14,
  parameter int SIZE_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctlWr,
  input  logic               sizeWr,
  input  logic [SIZE_W-1:0]  sizeBytes,
  input  logic               setupWr,
  input  logic [COUNT_W-1:0] setupCount,
  input  logic [1:0]         setupStartOff,
  input  logic [1:0]         setupEndOff,
  input  logic               setupBigEndian,
  input  logic               dataWr,
  input  logic [31:0]        dataWord,
  output logic               busy,
  output logic               setupErr,
  output logic               outValid,
  output logic [7:0]         outData,
  input  logic               outReady
);
  strobe_t strobe;

  tx_trim_ctrl #(.COUNT_W(COUNT_W), .SIZE_W(SIZE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .sizeWr(sizeWr),
    .sizeBytes(sizeBytes), .setupWr(setupWr), .setupCount(setupCount),
    .setupStartOff(setupStartOff), .setupEndOff(setupEndOff),
    .setupBigEndian(setupBigEndian), .dataWr(dataWr), .busy(busy),
    .setupErr(setupErr), .strobe(strobe)
  );

  tx_trim_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataWord(dataWord),
    .outReady(outReady), .outValid(outValid), .outData(outData), .busy(busy)
  );
endmodule

// File: rtl/tx_byte_trimmer_checker.sv
module tx_byte_trimmer_checker (
  input logic       clk,
  input logic       rstN,
  input logic       setupWr,
  input logic       dataWr,
  input logic       busy,
  input logic       setupErr,
  input logic       outValid,
  input logic [7:0] outData,
  input logic       outReady
);
  a_r8_valid_held: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);
  a_r8_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outData));
  a_r7_err_follows_setup: assert property (@(posedge clk) disable iff (!rstN)
    setupErr |-> $past(setupWr));
  a_r9_busy_from_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(dataWr));
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !outValid);
  a_r9_ignore_busy_write: assert property (@(posedge clk) disable iff (!rstN)
    busy && !outReady && dataWr |=> $stable(outData));
endmodule

bind tx_byte_trimmer tx_byte_trimmer_checker u_chk (
  .clk(clk), .rstN(rstN), .setupWr(setupWr), .dataWr(dataWr), .busy(busy),
  .setupErr(setupErr), .outValid(outValid), .outData(outData),
  .outReady(outReady)
);

// File: tb/tb_tx_byte_trimmer.sv
module tb_tx_byte_trimmer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlWr = 1'b0, sizeWr = 1'b0, setupWr = 1'b0, dataWr = 1'b0;
  logic [15:0] sizeBytes = '0;
  logic [13:0] setupCount = '0;
  logic [1:0]  setupStartOff = '0, setupEndOff = '0;
  logic        setupBigEndian = 1'b0;
  logic [31:0] dataWord = '0;
  logic        busy, setupErr, outValid, outReady = 1'b1;
  logic [7:0]  outData;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  tx_byte_trimmer dut (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .sizeWr(sizeWr),
    .sizeBytes(sizeBytes), .setupWr(setupWr), .setupCount(setupCount),
    .setupStartOff(setupStartOff), .setupEndOff(setupEndOff),
    .setupBigEndian(setupBigEndian), .dataWr(dataWr), .dataWord(dataWord),
    .busy(busy), .setupErr(setupErr), .outValid(outValid),
    .outData(outData), .outReady(outReady)
  );

  typedef struct packed {
    logic [15:0] size;
    logic [13:0] cnt;
    logic [1:0]  so;
    logic [1:0]  eo;
    logic        big;
    logic [31:0] expBytes;
    logic [2:0]  expN;
  } vec_t;

  localparam logic [31:0] W = 32'hA1B2C3D4;
  // expBytes holds the first transmitted byte in bits [7:0]
  localparam vec_t VECS [10] = '{
    '{16'd100, 14'd0, 2'd0, 2'd0, 1'b0, 32'hA1B2C3D4, 3'd4}, // R5 LSB first
    '{16'd100, 14'd0, 2'd0, 2'd0, 1'b1, 32'hD4C3B2A1, 3'd4}, // R5 MSB first
    '{16'd100, 14'd2, 2'd1, 2'd3, 1'b0, 32'h00A1B2C3, 3'd3}, // R2 R6 lead trim
    '{16'd100, 14'd2, 2'd3, 2'd0, 1'b1, 32'h000000D4, 3'd1}, // R2 R5
    '{16'd100, 14'd0, 2'd2, 2'd1, 1'b0, 32'h00B2C3D4, 3'd3}, // R2 R3 zero count
    '{16'd100, 14'd0, 2'd0, 2'd3, 1'b1, 32'h000000A1, 3'd1}, // R3 R6 tail trim
    '{16'd2,   14'd0, 2'd0, 2'd3, 1'b0, 32'h0000C3D4, 3'd2}, // R4 override
    '{16'd3,   14'd1, 2'd2, 2'd0, 1'b1, 32'h0000D4C3, 3'd2}, // R4 with lead
    '{16'd0,   14'd0, 2'd0, 2'd0, 1'b0, 32'h00000000, 3'd0}, // R4 zero left
    '{16'd1,   14'd0, 2'd0, 2'd0, 1'b1, 32'h000000A1, 3'd1}  // R4 R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doSetup(input logic [15:0] sz, input logic [13:0] c,
                         input logic [1:0] so, input logic [1:0] eo,
                         input logic big, input logic loads, output logic err);
    @(negedge clk);
    if (loads) begin
      ctlWr = 1'b1; sizeWr = 1'b1; sizeBytes = sz;
      @(negedge clk);
      ctlWr = 1'b0; sizeWr = 1'b0;
    end
    setupWr = 1'b1; setupCount = c; setupStartOff = so;
    setupEndOff = eo; setupBigEndian = big;
    @(negedge clk);
    setupWr = 1'b0;
    err = setupErr;
    @(negedge clk);
  endtask

  task automatic hostWrite(input logic [31:0] w);
    @(negedge clk);
    while (busy) @(negedge clk);
    dataWr = 1'b1; dataWord = w;
    @(negedge clk);
    dataWr = 1'b0;
  endtask

  task automatic collect(input logic slow, output int n, output logic [31:0] bytes);
    int k;
    n = 0; bytes = '0; k = 0;
    while (busy) begin
      outReady = slow ? k[0] : 1'b1;
      k++;
      if (outValid && outReady) begin
        if (n < 4) bytes[8*n +: 8] = outData;
        n++;
      end
      @(negedge clk);
    end
    outReady = 1'b1;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [31:0] b;
    logic err;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 busy", {31'd0, busy}, 32'd0);
    check("R10 outValid", {31'd0, outValid}, 32'd0);
    check("R10 setupErr", {31'd0, setupErr}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    foreach (VECS[i]) begin
      doSetup(VECS[i].size, VECS[i].cnt, VECS[i].so, VECS[i].eo, VECS[i].big, 1'b1, err);
      check("R7 no error on loaded setup", {31'd0, err}, 32'd0);
      hostWrite(W);
      collect(i[0], n, b);
      check("R4 R6 byte count", n, {29'd0, VECS[i].expN});
      check("R5 R6 bytes", b, VECS[i].expBytes);
    end

    // R1 R2 R4 buffer: size 10, four writes, countdown 2
    doSetup(16'd10, 14'd2, 2'd1, 2'd2, 1'b0, 1'b1, err);
    hostWrite(32'h44332211); collect(1'b0, n, b);
    check("R2 first word lead trim", b, 32'h00443322);
    hostWrite(32'h88776655); collect(1'b1, n, b);
    check("R2 lead trim cleared", n, 4);
    check("R1 second word bytes", b, 32'h88776655);
    hostWrite(32'hCCBBAA99); collect(1'b0, n, b);
    check("R1 R4 count zero, remainder 3 overrides tail", n, 3);
    check("R4 remainder bytes", b, 32'h00BBAA99);
    hostWrite(32'h0F0E0D0C); collect(1'b0, n, b);
    check("R4 nothing left", n, 0);
    check("R9 no busy for empty word", {31'd0, busy}, 32'd0);

    // R3 tail trim persists
    doSetup(16'd100, 14'd0, 2'd0, 2'd2, 1'b1, 1'b1, err);
    hostWrite(W); collect(1'b0, n, b);
    check("R3 first tail trim", b, 32'h0000B2A1);
    hostWrite(W); collect(1'b0, n, b);
    check("R3 tail trim persists", b, 32'h0000B2A1);
    check("R1 count holds zero", n, 2);

    // R7 setup without loads
    doSetup(16'd100, 14'd3, 2'd1, 2'd0, 1'b0, 1'b0, err);
    check("R7 setupErr pulse", {31'd0, err}, 32'd1);
    check("R7 setupErr one cycle", {31'd0, setupErr}, 32'd0);
    hostWrite(W); collect(1'b0, n, b);
    check("R7 old settings kept", b, 32'h0000B2A1);

    // R9 write while busy ignored, R8 backpressure
    doSetup(16'd100, 14'd0, 2'd0, 2'd0, 1'b0, 1'b1, err);
    outReady = 1'b0;
    hostWrite(W);
    check("R9 busy after write", {31'd0, busy}, 32'd1);
    dataWr = 1'b1; dataWord = 32'h11223344;
    @(negedge clk);
    dataWr = 1'b0;
    check("R8 first byte held", {24'd0, outData}, 32'h000000D4);
    collect(1'b1, n, b);
    check("R9 only first word emitted", b, W);
    check("R9 byte count", n, 4);
    repeat (3) @(negedge clk);
    check("R9 no extra word", {31'd0, outValid}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule